// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block links a processor-side data port A to two memory-side ports, 1B and 2B, each `W` bits wide (12 by default). It serves memory interleaving, where one processor word goes to an even bank on 1B and an odd bank on 2B, and address multiplexing, where values from both banks are captured and then presented to the processor in turn.

Four holding registers carry the traffic. Two sit in the outbound direction, one in front of each B port. Two sit in the return direction, one behind each B port, and a select signal picks which of these drives A.

Each holding register has its own capture enable. While the enable is high, the register reloads from its input on every clock, so its output follows the input one cycle later. While the enable is low, it keeps its value. Each port has its own active-low output enable. A disabled port drives zero on its data output and clears its drive flag; the drive flag stands in for a tri-state pad.

Top module: `tri_port_exchanger`

## Requirements
- R1: A synchronous active-high `rst` clears all four holding registers. With all output enables low after reset, `a_out`, `b1_out` and `b2_out` read zero and all three drive flags read 1.
- R2: While `cap_a1` is high at a rising clock edge, `b1_out` shows the `a_in` value from that edge from that edge on. A run of consecutive high cycles streams `a_in` to 1B with one cycle of latency.
- R3: `cap_a2` loads the outbound 2B register from `a_in` in the same way. The 1B and 2B outbound registers load only under their own enables.
- R4: `cap_1a` captures `b1_in` into the 1B return register, and `cap_2a` captures `b2_in` into the 2B return register. Each captures independently of the other.
- R5: A register whose enable is low keeps its value on every clock edge, whatever its data input does.
- R6: `sel_1b` = 1 puts the 1B return register on `a_out`. `sel_1b` = 0 puts the 2B return register there. The choice takes effect without waiting for a clock edge.
- R7: A port whose output enable (`a_oe_n`, `b1_oe_n`, `b2_oe_n`) is 1 shows zero on its data output and 0 on its drive flag. Disabling and re-enabling the port does not change the stored value.
- R8: With one B port enabled and the other disabled, the enabled port keeps driving its held value while the disabled port's input is captured and returned to A.
- R9: With `cap_a1` and `cap_a2` both high, a single `a_in` value is loaded into both B ports at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data arriving on port A |
| b1_in | input | W | Data arriving on port 1B |
| b2_in | input | W | Data arriving on port 2B |
| cap_a1 | input | 1 | Capture enable, A to 1B register |
| cap_a2 | input | 1 | Capture enable, A to 2B register |
| cap_1a | input | 1 | Capture enable, 1B to A register |
| cap_2a | input | 1 | Capture enable, 2B to A register |
| sel_1b | input | 1 | Return select: 1 takes the 1B register, 0 takes the 2B register |
| a_oe_n | input | 1 | Active-low output enable, port A |
| b1_oe_n | input | 1 | Active-low output enable, port 1B |
| b2_oe_n | input | 1 | Active-low output enable, port 1B's partner 2B |
| a_out | output | W | Data driven on port A |
| b1_out | output | W | Data driven on port 1B |
| b2_out | output | W | Data driven on port 2B |
| a_drv | output | 1 | Port A driving flag |
| b1_drv | output | 1 | Port 1B driving flag |
| b2_drv | output | 1 | Port 2B driving flag |

## Verification
The bound checker watches, on every cycle, four things:
- that a loaded outbound value appears one cycle later;
- that a held outbound value does not move;
- that the selected return register reaches A after capture;
- that a disabled port reads zero and does not drive.

Only the directed scenarios can show the following:
- that the return select switches banks combinationally, between clock edges;
- that a value survives a disable and re-enable of its port;
- that one B port streams while the other receives;
- that a single A value fans out to both banks at once.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    localparam int NUM_HOLD = 4;

    typedef enum logic [1:0] {
        H_A_TO_1B = 2'd0,
        H_A_TO_2B = 2'd1,
        H_1B_TO_A = 2'd2,
        H_2B_TO_A = 2'd3
    } hold_idx_e;
endpackage

// File: rtl/hold_reg.sv
module hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] val;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.val;
endmodule

// File: rtl/port_drive.sv
module port_drive #(
    parameter int W = 12
) (
    input  logic         oe_n,
    input  logic [W-1:0] data,
    output logic [W-1:0] dout,
    output logic         drv
);
    always_comb begin
        drv  = ~oe_n;
        dout = oe_n ? '0 : data;
    end
endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
    import xchg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         cap_a1,
    input  logic         cap_a2,
    input  logic         cap_1a,
    input  logic         cap_2a,
    input  logic         sel_1b,
    input  logic         a_oe_n,
    input  logic         b1_oe_n,
    input  logic         b2_oe_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b2_out,
    output logic         a_drv,
    output logic         b1_drv,
    output logic         b2_drv
);
    logic [W-1:0] hold_din [NUM_HOLD];
    logic [W-1:0] hold_q   [NUM_HOLD];
    logic         hold_en  [NUM_HOLD];
    logic [W-1:0] ret_sel;

    always_comb begin
        hold_din[H_A_TO_1B] = a_in;
        hold_din[H_A_TO_2B] = a_in;
        hold_din[H_1B_TO_A] = b1_in;
        hold_din[H_2B_TO_A] = b2_in;
        hold_en[H_A_TO_1B]  = cap_a1;
        hold_en[H_A_TO_2B]  = cap_a2;
        hold_en[H_1B_TO_A]  = cap_1a;
        hold_en[H_2B_TO_A]  = cap_2a;
    end

    for (genvar g = 0; g < NUM_HOLD; g++) begin : g_hold
        hold_reg #(.W(W)) hold_i (
            .clk  (clk),
            .rst  (rst),
            .load (hold_en[g]),
            .din  (hold_din[g]),
            .dout (hold_q[g])
        );
    end

    always_comb begin
        ret_sel = sel_1b ? hold_q[H_1B_TO_A] : hold_q[H_2B_TO_A];
    end

    port_drive #(.W(W)) drv_a_i (
        .oe_n (a_oe_n),
        .data (ret_sel),
        .dout (a_out),
        .drv  (a_drv)
    );

    port_drive #(.W(W)) drv_b1_i (
        .oe_n (b1_oe_n),
        .data (hold_q[H_A_TO_1B]),
        .dout (b1_out),
        .drv  (b1_drv)
    );

    port_drive #(.W(W)) drv_b2_i (
        .oe_n (b2_oe_n),
        .data (hold_q[H_A_TO_2B]),
        .dout (b2_out),
        .drv  (b2_drv)
    );
endmodule

// File: rtl/exchanger_chk.sv
module exchanger_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b2_in,
    input logic         cap_a1,
    input logic         cap_a2,
    input logic         cap_1a,
    input logic         cap_2a,
    input logic         sel_1b,
    input logic         a_oe_n,
    input logic         b1_oe_n,
    input logic         b2_oe_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b1_out,
    input logic [W-1:0] b2_out,
    input logic         a_drv,
    input logic         b1_drv,
    input logic         b2_drv
);
    // R2
    load_b1_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cap_a1) && !b1_oe_n) |-> (b1_out == $past(a_in)));

    // R3
    load_b2_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cap_a2) && !b2_oe_n) |-> (b2_out == $past(a_in)));

    // R5
    hold_b1_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!cap_a1) && !b1_oe_n && $past(!b1_oe_n)) |-> $stable(b1_out));

    // R6
    ret_1b_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cap_1a) && sel_1b && !a_oe_n) |-> (a_out == $past(b1_in)));

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        a_oe_n |-> (a_out == '0 && !a_drv));
endmodule

bind tri_port_exchanger exchanger_chk #(.W(W)) chk_i (.*);

// File: tb/tri_port_exchanger_tb_top.sv
module tri_port_exchanger_tb_top;
    localparam int  W       = 12;
    localparam time CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         cap_a1 = 0, cap_a2 = 0, cap_1a = 0, cap_2a = 0;
    logic         sel_1b = 0, a_oe_n = 0, b1_oe_n = 0, b2_oe_n = 0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drv, b1_drv, b2_drv;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    tri_port_exchanger #(.W(W)) dut_i (.*);

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 a_out",  a_out,  '0);
        chk("R1 b1_out", b1_out, '0);
        chk("R1 b2_out", b2_out, '0);
        chk("R1 drv",    {9'd0, a_drv, b1_drv, b2_drv}, 12'h007);
    endtask

    task automatic t_outbound();
        a_in = 12'hA5C; cap_a1 = 1; tick();
        chk("R2 b1 load",      b1_out, 12'hA5C);
        chk("R3 b2 untouched", b2_out, 12'h000);
        for (int i = 0; i < 4; i++) begin
            a_in = 12'h100 + 12'(i); tick();
            chk("R2 stream", b1_out, 12'h100 + 12'(i));
        end
        cap_a1 = 0; cap_a2 = 1; a_in = 12'h3C3; tick();
        chk("R3 b2 load",  b2_out, 12'h3C3);
        chk("R5 b1 kept",  b1_out, 12'h103);
        cap_a2 = 0;
    endtask

    task automatic t_fanout();
        cap_a1 = 1; cap_a2 = 1; a_in = 12'h7E1; tick();
        cap_a1 = 0; cap_a2 = 0;
        chk("R9 b1", b1_out, 12'h7E1);
        chk("R9 b2", b2_out, 12'h7E1);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) begin
            a_in = ~a_in ^ 12'(i); b1_in = 12'(i * 37); b2_in = ~b1_in; tick();
        end
        chk("R5 b1 hold", b1_out, 12'h7E1);
        chk("R5 b2 hold", b2_out, 12'h7E1);
        chk("R5 a hold",  a_out,  12'h000);
    endtask

    task automatic t_return();
        b1_in = 12'h1B1; b2_in = 12'h2B2; cap_1a = 1; cap_2a = 1; tick();
        cap_1a = 0; cap_2a = 0;
        b1_in = 12'hFFF; b2_in = 12'h000;
        sel_1b = 1; #1;
        chk("R6 sel 1B", a_out, 12'h1B1);
        sel_1b = 0; #1;
        chk("R6 sel 2B", a_out, 12'h2B2);
        tick(); tick();
        chk("R5 ret hold", a_out, 12'h2B2);
        b2_in = 12'h0F0; cap_2a = 1; tick(); cap_2a = 0;
        sel_1b = 1; #1;
        chk("R4 1B indep", a_out, 12'h1B1);
        sel_1b = 0; #1;
        chk("R4 2B cap", a_out, 12'h0F0);
    endtask

    task automatic t_oe();
        a_oe_n = 1; b1_oe_n = 1; #1;
        chk("R7 a off",  a_out,  '0);
        chk("R7 b1 off", b1_out, '0);
        chk("R7 drv",    {10'd0, a_drv, b1_drv}, 12'h000);
        tick();
        a_oe_n = 0; b1_oe_n = 0; #1;
        chk("R7 a back",  a_out,  12'h0F0);
        chk("R7 b1 back", b1_out, 12'h7E1);
    endtask

    task automatic t_split();
        b2_oe_n = 1; b2_in = 12'h5A5; cap_2a = 1; sel_1b = 0; a_in = 12'h999; tick();
        cap_2a = 0;
        chk("R8 b1 drives", b1_out, 12'h7E1);
        chk("R8 b1_drv",    {11'd0, b1_drv}, 12'h001);
        chk("R8 b2 quiet",  {11'd0, b2_drv}, 12'h000);
        chk("R8 a return",  a_out, 12'h5A5);
        b2_oe_n = 0;
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_outbound();
        t_fanout();
        t_hold();
        t_return();
        t_oe();
        t_split();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule